// File: doc/BRIEF.md
# Two-Wire Register-Bank Slave

This block is a target on a two-wire SMBus/I2C-style bus. It runs entirely on the system clock. The SCL and SDA pins are oversampled through synchronizer flops, and the sampled levels are decoded into START, STOP, rising-clock and falling-clock events. The block answers one 7-bit device address. It serves a small bank of byte-wide control registers through the write-byte and read-byte transfers. The bank is presented as a flat parallel bus, so surrounding logic can read every register at once.

A write sends the address with R/W low, then a command byte (the register index), then one data byte. The data byte is not written straight away. It is held in a staging register and copied into the bank only when the master closes the transfer cleanly, with either STOP or a repeated START. A transfer cut short by START or STOP discards whatever was staged.

A read sends the address with R/W high. The block then shifts out the register selected by the most recently accepted command byte, which may come from an earlier transaction. The slave never drives SDA high. Its output is an open-drain pull-low enable.

Top module: `smb_regbank_slave`

## Requirements
- R1: While reset is held and right after it, `sda_oe` is 0 and every register shows its reset value (RST_VAL slice i, bits [8i+7:8i], for register i).
- R2: The slave pulls SDA low during the 9th clock of an address byte whose upper seven bits equal DEV_ADDR. Bit 0 of that byte is R/W, with 0 meaning write and 1 meaning read. Any other address gets no acknowledge, and until the next START the slave keeps SDA released and changes no register.
- R3: A command byte with a value from 0 to NREG-1 is acknowledged and becomes the register pointer. Any larger value is not acknowledged, later bytes of that transfer are not acknowledged, and no register changes.
- R4: In a write (address with R/W=0, then command, then data), the data byte is acknowledged. The target register keeps its old value through that acknowledge and takes the new value at the following STOP.
- R5: A repeated START also commits a completed staged write, before the new address phase begins.
- R6: A START or STOP that arrives before the 8th bit of the data byte discards the write. A transfer that carries only a command byte changes no register.
- R7: Register i stores only the bits set in WMASK slice i. All other bits read 0 whatever is written to them.
- R8: After an acknowledged read address, the slave shifts out the pointed register MSB first, one bit per SCL clock, with `sda_oe` = NOT bit. Each master ACK (SDA low in the 9th clock) makes the slave send the same register again.
- R9: After a master NACK (SDA high in the 9th clock of a read byte), the slave keeps SDA released until the next START or STOP.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_flat | output | NREG*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
Two events can land in the same system-clock cycle: the commit of a pending write and the START decode that restarts the address phase. The bench provokes this with a write whose data byte is followed directly by a repeated START and then a read address with no command byte. The case passes only if the register already holds the masked data right after the restart and the read returns that same value through the retained pointer. The same pattern is repeated with STOP and with transfers cut short in mid-byte, to show that a START or STOP without a completed byte commits nothing.

// File: rtl/smb_pkg.sv
package smb_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = 4;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_WDATA,
      PH_RDATA,
      PH_HOLD
   } phase_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_in};
         sda_ff <= {sda_ff[STAGES-2:0], sda_in};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = !scl_q && scl_s;
   assign scl_fall = scl_q && !scl_s;
   assign start_p  = scl_q && scl_s && sda_q && !sda_s;
   assign stop_p   = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
   import smb_pkg::*;
#(
   parameter int                     NREG    = 7,
   parameter int                     PTR_W   = 3,
   parameter logic [NREG*BYTE_W-1:0] RST_VAL = '0,
   parameter logic [NREG*BYTE_W-1:0] WMASK   = '1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [PTR_W-1:0]         wr_idx,
   input  byte_t                    wr_data,
   input  logic [PTR_W-1:0]         rd_idx,
   output byte_t                    rd_data,
   output logic [NREG*BYTE_W-1:0]   regs_flat
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam byte_t RV = RST_VAL[i*BYTE_W +: BYTE_W];
      localparam byte_t WM = WMASK[i*BYTE_W +: BYTE_W];
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RV;
         else if (wr_en && wr_idx == PTR_W'(i))
            q <= wr_data & WM;
      end
      assign regs_flat[i*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (rd_idx == PTR_W'(i)) rd_data = regs_flat[i*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
   import smb_pkg::*;
#(
   parameter int                NREG     = 7,
   parameter int                PTR_W    = 3,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_p,
   input  logic             stop_p,
   input  byte_t            rd_byte,
   output logic             sda_oe,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output byte_t            wr_data,
   output logic [PTR_W-1:0] ptr_o,
   output logic             settled
);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

   phase_e           phase;
   logic [CNT_W-1:0] bitcnt;
   byte_t            shreg, txreg, stage;
   logic             pending, ackd, mnack, accept, receiving;
   logic [PTR_W-1:0] ptr;

   always_comb begin
      case (phase)
         PH_ADDR:  accept = (shreg[BYTE_W-1:1] == DEV_ADDR);
         PH_CMD:   accept = (int'(shreg) < NREG);
         PH_WDATA: accept = 1'b1;
         default:  accept = 1'b0;
      endcase
   end

   assign receiving = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_WDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         stage   <= '0;
         pending <= 1'b0;
         ackd    <= 1'b0;
         mnack   <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
      end else if (start_p) begin
         phase   <= PH_ADDR;
         bitcnt  <= '0;
         sda_oe  <= 1'b0;
         pending <= 1'b0;
      end else if (stop_p) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         sda_oe  <= 1'b0;
         pending <= 1'b0;
      end else if (receiving) begin
         if (scl_rise) begin
            if (bitcnt < ACK_SLOT) shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (bitcnt < ACK_DONE) bitcnt <= bitcnt + 1'b1;
         end else if (scl_fall) begin
            if (bitcnt == ACK_SLOT) begin
               sda_oe <= accept;
               ackd   <= accept;
            end else if (bitcnt == ACK_DONE) begin
               bitcnt <= '0;
               sda_oe <= 1'b0;
               if (!ackd)
                  phase <= PH_HOLD;
               else if (phase == PH_ADDR) begin
                  if (shreg[0]) begin
                     phase  <= PH_RDATA;
                     txreg  <= rd_byte;
                     sda_oe <= !rd_byte[BYTE_W-1];
                  end else
                     phase <= PH_CMD;
               end else if (phase == PH_CMD) begin
                  ptr   <= shreg[PTR_W-1:0];
                  phase <= PH_WDATA;
               end else begin
                  stage   <= shreg;
                  pending <= 1'b1;
                  phase   <= PH_HOLD;
               end
            end
         end
      end else if (phase == PH_RDATA) begin
         if (scl_rise) begin
            if (bitcnt == ACK_SLOT) mnack <= sda_s;
            if (bitcnt < ACK_DONE) bitcnt <= bitcnt + 1'b1;
         end else if (scl_fall) begin
            if (bitcnt != '0 && bitcnt < ACK_SLOT) begin
               txreg  <= {txreg[BYTE_W-2:0], 1'b0};
               sda_oe <= !txreg[BYTE_W-2];
            end else if (bitcnt == ACK_SLOT)
               sda_oe <= 1'b0;
            else if (bitcnt == ACK_DONE) begin
               bitcnt <= '0;
               if (mnack) begin
                  phase  <= PH_HOLD;
                  sda_oe <= 1'b0;
               end else begin
                  txreg  <= rd_byte;
                  sda_oe <= !rd_byte[BYTE_W-1];
               end
            end
         end
      end
   end

   assign wr_en   = pending && (start_p || stop_p);
   assign wr_idx  = ptr;
   assign wr_data = stage;
   assign ptr_o   = ptr;
   assign settled = (phase == PH_HOLD) || (phase == PH_IDLE);
endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
   import smb_pkg::*;
#(
   parameter int                     NREG        = 7,
   parameter logic [ADDR_W-1:0]      DEV_ADDR    = 7'h2C,
   parameter int                     SYNC_STAGES = 2,
   parameter logic [NREG*BYTE_W-1:0] RST_VAL     = 56'h20_00_05_80_40_10_01,
   parameter logic [NREG*BYTE_W-1:0] WMASK       = 56'h3F_FF_1F_FF_7F_FF_83
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_in,
   input  logic                   sda_in,
   output logic                   sda_oe,
   output logic [NREG*BYTE_W-1:0] regs_flat
);
   localparam int PTR_W = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG < 2 || NREG > (1 << BYTE_W)) begin : g_bad_nreg
      $fatal(1, "NREG must lie between 2 and 256");
   end
   if ((RST_VAL & ~WMASK) != '0) begin : g_bad_rst
      $fatal(1, "reset values must be zero in reserved bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "at least two synchronizer stages are required");
   end

   logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic             wr_en, settled;
   logic [PTR_W-1:0] wr_idx, ptr;
   byte_t            wr_data, rd_byte;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p)
   );

   smb_proto_fsm #(.NREG(NREG), .PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
      .rd_byte(rd_byte), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .ptr_o(ptr), .settled(settled)
   );

   smb_reg_bank #(.NREG(NREG), .PTR_W(PTR_W), .RST_VAL(RST_VAL), .WMASK(WMASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_byte), .regs_flat(regs_flat)
   );
endmodule

// File: rtl/smb_regbank_slave_chk.sv
module smb_regbank_slave_chk #(
   parameter int               NREG    = 7,
   parameter logic [NREG*8-1:0] RST_VAL = '0,
   parameter logic [NREG*8-1:0] WMASK   = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_p,
   input logic              stop_p,
   input logic              sda_oe,
   input logic              settled,
   input logic [NREG*8-1:0] regs_flat
);
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_state_R1: assert (sda_oe == 1'b0 && regs_flat == RST_VAL)
            else $error("reset state wrong");
      end
   end

   assert_commit_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_flat) |-> $past(start_p || stop_p))
      else $error("register changed outside a bus condition");

   assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_flat & ~WMASK) == '0)
      else $error("reserved bit set");

   assert_released_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      settled |-> !sda_oe)
      else $error("SDA driven while transfer is finished");

   assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(start_p || stop_p)) |-> !scl_s)
      else $error("sda_oe changed while SCL high");
endmodule

bind smb_regbank_slave smb_regbank_slave_chk #(
   .NREG(NREG), .RST_VAL(RST_VAL), .WMASK(WMASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_p(start_p), .stop_p(stop_p),
   .sda_oe(sda_oe), .settled(settled), .regs_flat(regs_flat)
);

// File: tb/smb_regbank_slave_test.sv
module smb_regbank_slave_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int          NREG = 7;
   localparam logic [6:0]  DEV  = 7'h2C;
   localparam logic [55:0] RSTV = 56'h20_00_05_80_40_10_01;
   localparam logic [55:0] MSK  = 56'h3F_FF_1F_FF_7F_FF_83;
   localparam int          Q    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_oe;
   logic [55:0] regs_flat;
   logic        sda_line;
   int          n_chk = 0;
   int          n_fail = 0;
   int          r10_viol = 0;
   logic        oe_prev = 1'b0;
   logic [7:0]  exp_r [NREG];

   always #2.5 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   smb_regbank_slave #(.NREG(NREG), .DEV_ADDR(DEV), .RST_VAL(RSTV), .WMASK(MSK)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
      .sda_oe(sda_oe), .regs_flat(regs_flat)
   );

   always @(negedge clk) begin
      if (sda_oe !== oe_prev && m_scl) r10_viol++;
      oe_prev = sda_oe;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic chk_regs(input string tag);
      for (int r = 0; r < NREG; r++)
         chk(regs_flat[r*8 +: 8] == exp_r[r], tag, 32'(regs_flat[r*8 +: 8]), 32'(exp_r[r]));
   endtask

   function automatic logic [7:0] msk(input int r);
      return MSK[r*8 +: 8];
   endfunction

   task automatic half();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b0; half(); m_scl = 1'b0; half();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      m_sda = 1'b1; half(); m_scl = 1'b1;
      repeat (Q/2) @(negedge clk);
      ack = sda_oe;
      repeat (Q - Q/2) @(negedge clk);
      m_scl = 1'b0;
   endtask

   task automatic recv_byte(input logic mnack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         m_sda = 1'b1; half(); m_scl = 1'b1;
         repeat (Q/2) @(negedge clk);
         b[i] = ~sda_oe;
         repeat (Q - Q/2) @(negedge clk);
         m_scl = 1'b0;
      end
      m_sda = mnack; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
   endtask

   initial begin
      logic       ack;
      logic [7:0] rb, v;
      #1 rst_n = 1'b0;
      for (int r = 0; r < NREG; r++) exp_r[r] = RSTV[r*8 +: 8];
      repeat (5) @(negedge clk);
      chk_regs("R1 reset values");
      chk(sda_oe == 1'b0, "R1 sda released", 32'(sda_oe), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_regs("R1 after reset");

      // R4, R7, R8, R2, R3: write every register with two complementary patterns
      for (int p = 0; p < 2; p++) begin
         for (int r = 0; r < NREG; r++) begin
            v = 8'(r * 8'h47) ^ 8'hA6;
            if (p == 1) v = ~v;
            bus_start();
            send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack", 32'(ack), 1);
            send_byte(8'(r), ack);       chk(ack, "R3 command ack", 32'(ack), 1);
            send_byte(v, ack);           chk(ack, "R4 data ack", 32'(ack), 1);
            half();
            chk_regs("R4 no update before STOP");
            bus_stop();
            exp_r[r] = v & msk(r);
            chk_regs("R4 R7 committed at STOP with mask");
            bus_start();
            send_byte({DEV, 1'b0}, ack);
            send_byte(8'(r), ack);
            bus_start();
            send_byte({DEV, 1'b1}, ack); chk(ack, "R2 read address ack", 32'(ack), 1);
            recv_byte(1'b1, rb);
            chk(rb == exp_r[r], "R8 readback", 32'(rb), 32'(exp_r[r]));
            bus_stop();
         end
      end

      // R3: out-of-range command values
      for (int c = NREG; c < 20; c++) begin
         bus_start();
         send_byte({DEV, 1'b0}, ack);
         send_byte(8'(c == 19 ? 255 : c), ack); chk(!ack, "R3 bad command nack", 32'(ack), 0);
         send_byte(8'h00, ack);                 chk(!ack, "R3 data after bad command", 32'(ack), 0);
         bus_stop();
         chk_regs("R3 no change");
      end

      // R2: every single-bit address error, write and read
      for (int k = 0; k < 7; k++) begin
         bus_start();
         send_byte({DEV ^ 7'(1 << k), 1'b0}, ack); chk(!ack, "R2 foreign address", 32'(ack), 0);
         send_byte(8'h01, ack);                    chk(!ack, "R2 ignored byte", 32'(ack), 0);
         send_byte(8'h00, ack);                    chk(!ack, "R2 ignored byte", 32'(ack), 0);
         bus_stop();
         chk_regs("R2 no change");
         bus_start();
         send_byte({DEV ^ 7'(1 << k), 1'b1}, ack);
         recv_byte(1'b1, rb); chk(rb == 8'hFF, "R2 no drive on foreign read", 32'(rb), 32'hFF);
         bus_stop();
      end

      // R5: commit at repeated START, then read through the kept pointer (R8)
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd2, ack);
      send_byte(8'hBC, ack);
      chk_regs("R5 not yet committed");
      bus_start();
      exp_r[2] = 8'hBC & msk(2);
      chk_regs("R5 committed at repeated START");
      send_byte({DEV, 1'b1}, ack);
      recv_byte(1'b1, rb);
      chk(rb == exp_r[2], "R8 read with no command byte", 32'(rb), 32'(exp_r[2]));
      bus_stop();

      // R6: premature STOP and START, and a command-only write
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd3, ack);
      send_bits(8'h5E, 4);
      bus_stop();
      chk_regs("R6 partial byte then STOP");
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd4, ack);
      send_bits(8'h1B, 7);
      bus_start();
      bus_stop();
      chk_regs("R6 partial byte then START");
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd5, ack);
      bus_stop();
      chk_regs("R6 command only");
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      recv_byte(1'b1, rb);
      chk(rb == exp_r[5], "R8 pointer from earlier transfer", 32'(rb), 32'(exp_r[5]));
      bus_stop();

      // R8 repeated bytes on master ACK, R9 release after NACK
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd1, ack);
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      for (int n = 0; n < 3; n++) begin
         recv_byte(n == 2, rb);
         chk(rb == exp_r[1], "R8 same register on ACK", 32'(rb), 32'(exp_r[1]));
      end
      recv_byte(1'b1, rb);
      chk(rb == 8'hFF, "R9 released after NACK", 32'(rb), 32'hFF);
      bus_stop();
      chk_regs("R9 no change");

      chk(r10_viol == 0, "R10 sda_oe moves only with SCL low", 32'(r10_viol), 0);
      summary();
   end
endmodule